// File: doc/BRIEF.md
# Error-Tolerant Approximate Adder

This block adds two 64-bit operands with a deliberate approximation in the low-order bits. The word is split at a parameter boundary. The upper 24 bits go through an exact ripple-carry adder whose carry-in is held at zero. The lower 40 bits are summed with no carries at all: each bit is the XOR of its operand bits, unless a control signal forces it to one. It suits datapaths such as image and signal filters, where a small error in the low bits is acceptable in return for a short carry path and little switching.

A control generator scans the low field from its top bit downward. At the highest position where both operand bits are 1, it raises the control for that bit and for every bit below it. The low sum therefore saturates to all ones from that point down. The generator is built from per-bit cells in groups of four. Each group also passes an "any both-one seen" flag to the group below, so a high control skips over whole groups instead of rippling through every cell.

The 65-bit result is laid out from the top as follows: the carry-out of the exact part, then the 24-bit exact sum, then the 40-bit approximate sum. By default the result goes through one output register.

Top module: `eta_adder`

## Requirements
- R1: `sum_o[63:40]` is the 24-bit sum `a_i[63:40] + b_i[63:40]` with a carry-in of zero. No carry from bits 39:0 ever reaches it.
- R2: When no bit position `i` in 39:0 has `a_i[i] = b_i[i] = 1`, `sum_o[39:0]` equals `a_i[39:0] ^ b_i[39:0]`.
- R3: Let `k` be the highest position in 39:0 where both operand bits are 1. Then every bit of `sum_o[k:0]` is 1.
- R4: For positions `i` in 39:0 above that `k`, `sum_o[i] = a_i[i] ^ b_i[i]`.
- R5: A both-one position in one group of four forces to 1 every bit in all lower groups, even where those groups have no both-one position of their own.
- R6: When no position in 39:0 has both operand bits set, `sum_o` equals the exact 65-bit sum `a_i + b_i`.
- R7: The output is registered. Operands present at a rising clock edge appear on `sum_o` after that edge and not before. While `rst_ni` is low, `sum_o` is all zeros.
- R8: `sum_o[64]` is the carry-out of the exact 24-bit addition of bits 63:40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the output register |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| sum_o | output | 65 | Carry-out, then the exact upper sum, then the approximate lower sum |

## Verification
The exact upper adder and the low-field saturation act on the same operands in the same cycle, so the risky case is when both are busy at once. The bench provokes this with operands that overflow the exact part while the low field saturates, for example all ones on both inputs. The result must then show the carry-out, the exact upper sum and a low field of all ones, with nothing leaking across the boundary. An operand pair whose true sum would carry out of bit 39 is judged the same way: the upper bits must stay at their carry-free value.

// File: rtl/eta_pkg.sv
package eta_pkg;
  localparam int unsigned ETA_WIDTH = 64;
  localparam int unsigned ETA_LOW_W = 40;
  localparam int unsigned ETA_GRP_W = 4;
endpackage

// File: rtl/eta_rca.sv
// Exact ripple-carry part, carry-in tied low.
module eta_rca #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
    assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = carry[W];
endmodule

// File: rtl/eta_ctl_cell.sv
// One control cell: high if control arrives from above or this bit generates.
module eta_ctl_cell (
  input  logic ctl_in_i,
  input  logic gen_i,
  output logic ctl_o
);
  assign ctl_o = ctl_in_i | gen_i;
endmodule

// File: rtl/eta_ctl_gen.sv
// Grouped control chain with skip links between groups.
module eta_ctl_gen #(
  parameter int unsigned LOW_W = 40,
  parameter int unsigned GRP_W = 4
) (
  input  logic [LOW_W-1:0] a_i,
  input  logic [LOW_W-1:0] b_i,
  output logic [LOW_W-1:0] ctl_o
);
  localparam int unsigned N_GRP = LOW_W / GRP_W;

  logic [LOW_W-1:0] gen;
  logic [N_GRP:0]   skip;   // skip[g]: a both-one position seen in group g or above

  assign gen         = a_i & b_i;
  assign skip[N_GRP] = 1'b0;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign skip[g] = skip[g+1] | (|gen[g*GRP_W +: GRP_W]);
    for (genvar j = 0; j < GRP_W; j++) begin : g_cell
      localparam int unsigned IDX = g * GRP_W + j;
      if (j == GRP_W - 1) begin : g_lead
        eta_ctl_cell u_cell (
          .ctl_in_i (skip[g+1]),
          .gen_i    (gen[IDX]),
          .ctl_o    (ctl_o[IDX])
        );
      end else begin : g_follow
        eta_ctl_cell u_cell (
          .ctl_in_i (ctl_o[IDX+1]),
          .gen_i    (gen[IDX]),
          .ctl_o    (ctl_o[IDX])
        );
      end
    end
  end

  // Controls form a thermometer code from the top both-one position downward.
  always_comb begin
    for (int i = 1; i < LOW_W; i++) begin
      p_ctl_thermo_r5: assert (!ctl_o[i] || ctl_o[i-1]);
      p_ctl_gen_r3:    assert (!gen[i] || ctl_o[i]);
    end
    p_ctl_top_r4: assert (ctl_o[LOW_W-1] == gen[LOW_W-1]);
  end
endmodule

// File: rtl/eta_xor_array.sv
// Carry-free sum: XOR per bit, forced high when its control is set.
module eta_xor_array #(
  parameter int unsigned LOW_W = 40
) (
  input  logic [LOW_W-1:0] a_i,
  input  logic [LOW_W-1:0] b_i,
  input  logic [LOW_W-1:0] ctl_i,
  output logic [LOW_W-1:0] sum_o
);
  for (genvar i = 0; i < LOW_W; i++) begin : g_bit
    assign sum_o[i] = ctl_i[i] ? 1'b1 : (a_i[i] ^ b_i[i]);
  end
endmodule

// File: rtl/eta_adder.sv
module eta_adder
  import eta_pkg::*;
#(
  parameter int unsigned WIDTH   = ETA_WIDTH,
  parameter int unsigned LOW_W   = ETA_LOW_W,
  parameter int unsigned GRP_W   = ETA_GRP_W,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH:0]   sum_o
);
  localparam int unsigned HIGH_W = WIDTH - LOW_W;

  logic [HIGH_W-1:0] hi_sum;
  logic              hi_cout;
  logic [LOW_W-1:0]  lo_ctl;
  logic [LOW_W-1:0]  lo_sum;
  logic [WIDTH:0]    sum_d;

  eta_rca #(.W(HIGH_W)) u_rca (
    .a_i    (a_i[WIDTH-1:LOW_W]),
    .b_i    (b_i[WIDTH-1:LOW_W]),
    .sum_o  (hi_sum),
    .cout_o (hi_cout)
  );

  eta_ctl_gen #(.LOW_W(LOW_W), .GRP_W(GRP_W)) u_ctl (
    .a_i   (a_i[LOW_W-1:0]),
    .b_i   (b_i[LOW_W-1:0]),
    .ctl_o (lo_ctl)
  );

  eta_xor_array #(.LOW_W(LOW_W)) u_xor (
    .a_i   (a_i[LOW_W-1:0]),
    .b_i   (b_i[LOW_W-1:0]),
    .ctl_i (lo_ctl),
    .sum_o (lo_sum)
  );

  assign sum_d = {hi_cout, hi_sum, lo_sum};

  if (OUT_REG) begin : g_oreg
    logic [WIDTH:0] sum_q;
    logic           valid_q;  // register holds a captured result

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_q   <= '0;
        valid_q <= 1'b0;
      end else begin
        sum_q   <= sum_d;
        valid_q <= 1'b1;
      end
    end
    assign sum_o = sum_q;

    p_hi_exact_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |-> sum_o[WIDTH:LOW_W] ==
        ({1'b0, $past(a_i[WIDTH-1:LOW_W])} + {1'b0, $past(b_i[WIDTH-1:LOW_W])}));

    p_exact_no_gen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q && ($past(a_i[LOW_W-1:0] & b_i[LOW_W-1:0]) == '0)) |->
        sum_o == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)}));

    p_lsb_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q && ($past(a_i[LOW_W-1:0] & b_i[LOW_W-1:0]) != '0)) |-> sum_o[0]);

    p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_q |-> sum_o == '0);
  end else begin : g_comb
    assign sum_o = sum_d;
  end
endmodule

// File: tb/eta_adder_tb.sv
module eta_adder_tb;
  localparam int unsigned W  = 64;
  localparam int unsigned LW = 40;
  localparam int unsigned NV = 10;

  localparam logic [W-1:0] VA [NV] = '{
    64'h0000_0000_0000_0000, 64'h0123_4567_89AB_CDEF, 64'hAAAA_AAAA_AAAA_AAAA,
    64'hFFFF_FF00_0000_0000, 64'h8000_0000_0000_0001, 64'h0000_0088_0000_0000,
    64'h0000_0000_0F00_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_CAFE_F00D,
    64'h0000_0010_0000_0000};
  localparam logic [W-1:0] VB [NV] = '{
    64'h0000_0000_0000_0000, 64'h1010_1010_1010_1010, 64'h5555_5555_5555_5555,
    64'h0000_01FF_FFFF_FFFF, 64'h8000_0000_0000_0001, 64'h0000_0080_0000_0000,
    64'h0000_0000_0100_0000, 64'h0000_0000_0000_0001, 64'h1234_5678_9ABC_DEF0,
    64'h0000_0010_0000_0000};

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W:0]   sum_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  eta_adder u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (sum_o)
  );

  // Model built from the requirements: exact high part, scanned low part.
  function automatic logic [W:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-LW:0] hi;
    logic [LW-1:0] lo;
    logic          hit;
    hi  = {1'b0, a[W-1:LW]} + {1'b0, b[W-1:LW]};
    hit = 1'b0;
    for (int i = LW - 1; i >= 0; i--) begin
      if (a[i] && b[i]) hit = 1'b1;
      lo[i] = hit ? 1'b1 : (a[i] ^ b[i]);
    end
    return {hi, lo};
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    a_i = a;
    b_i = b;
    @(negedge clk_i);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [W:0] prev;
    // R7: reset holds the output at zero even with operands applied
    a_i = '1;
    b_i = '1;
    repeat (3) @(negedge clk_i);
    check("R7 reset", sum_o, '0);
    rst_ni = 1'b1;

    // Table walk: R3/R4 against the model, R2 and R6 when no both-one position
    for (int v = 0; v < NV; v++) begin
      apply(VA[v], VB[v]);
      check("R3/R4 table", sum_o, ref_sum(VA[v], VB[v]));
      if ((VA[v][LW-1:0] & VB[v][LW-1:0]) == '0) begin
        check("R2 low xor", {25'b0, sum_o[LW-1:0]}, {25'b0, VA[v][LW-1:0] ^ VB[v][LW-1:0]});
        check("R6 exact", sum_o, {1'b0, VA[v]} + {1'b0, VB[v]});
      end
    end

    // R8 and R3 together: high overflow while the low field saturates
    apply('1, '1);
    check("R8 cout with saturation", sum_o, 65'h1_FFFF_FEFF_FFFF_FFFF);

    // R5: both-one only at bit 39, all lower groups forced
    apply(64'h0000_0080_0000_0000, 64'h0000_0080_0000_0000);
    check("R5 skip", sum_o, 65'h0_0000_00FF_FFFF_FFFF);

    // R4: both-one at bit 5, xor kept at bit 8
    apply(64'h120, 64'h020);
    check("R4 above k", sum_o, 65'h13F);

    // R3: both-one at bit 0 only
    apply(64'h3, 64'h1);
    check("R3 lsb", sum_o, 65'h3);

    // R1: a carry from the low field would reach bit 40 but must not
    apply(64'h0000_00FF_FFFF_FFFF, 64'h1);
    check("R1 no leak", sum_o, 65'h0_0000_00FF_FFFF_FFFF);

    // R8/R6: exact overflow with zero low field
    apply(64'hFFFF_FF00_0000_0000, 64'h0000_0100_0000_0000);
    check("R8 cout", sum_o, 65'h1_0000_0000_0000_0000);

    // R7 latency: new operands not visible before the edge
    prev = sum_o;
    @(negedge clk_i);
    a_i = 64'h5;
    b_i = 64'h2;
    #2;
    check("R7 before edge", sum_o, prev);
    @(negedge clk_i);
    check("R7 after edge", sum_o, 65'h7);

    // R7: reset asserted mid-run clears the output
    rst_ni = 1'b0;
    #2;
    check("R7 async reset", sum_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R7 after release", sum_o, 65'h7);

    finish_up();
  end
endmodule